// File: doc/BRIEF.md
# Conversion Result Buffer with Byte-Serial Readout

This block stores conversion results from a scan sequencer in a sixteen-slot first-in/first-out buffer. A host drains the buffer through a chip-select-framed serial output. Each stored 12-bit result leaves as a 16-bit stream. The first byte carries four zero bits and then the top four result bits. The second byte carries the low eight bits. Every chip-select-low period is one frame, which normally lasts eight serial clocks. The host may end a frame early, and fixed rules then decide which bits the next frame carries.

The sequencer writes through a single-cycle push strobe. When the buffer is already holding sixteen results, a push silently discards the oldest one. A clear strobe empties the buffer. The buffer count and an empty flag are exported. The serial inputs are taken into the block clock domain through synchroniser chains, and serial clock edges are then detected on the sampled signals.

The readout controller is a four-state machine:
- **SO_IDLE**: chip select is high.
- **SO_LEAD**: a frame that starts at bit 0 of the oldest entry.
- **SO_TRAIL**: a frame that continues an entry already partly read.
- **SO_VOID**: a frame started while the buffer was empty.

Its transitions:
- **SO_IDLE → SO_VOID** on a chip-select fall with the buffer empty.
- **SO_IDLE → SO_LEAD** on a chip-select fall with the read position at zero.
- **SO_IDLE → SO_TRAIL** on a chip-select fall with the read position non-zero. This transition also pops the entry.
- **SO_LEAD, SO_TRAIL and SO_VOID → SO_IDLE** on a chip-select rise.

Top module: `conv_result_fifo`

## Requirements
- R1: After reset the buffer is empty: `count` is 0 and `empty` is 1. Each push into a non-full buffer raises `count` by one, and `count` never exceeds 16.
- R2: A push into a full buffer discards the oldest result and keeps the new one. `count` stays 16, and readout then starts with the second-oldest result.
- R3: An entry is read as two bytes, MSB first. The first byte is 0000 followed by result bits 11..8, and the second byte is result bits 7..0. The first bit appears on `sdo` after chip select falls. Each later bit appears after a falling edge of `sclk`.
- R4: `sdo_en` is 1 only while the sampled chip select is low. While it is 0, `sdo` is 0.
- R5: A frame started while the buffer is empty shifts out only zeros, and `count` is left unchanged.
- R6: If the host ends a first-byte frame after k < 8 bits, the next frame carries stream bits k to k+7 of that entry, counted from the MSB of the 16-bit stream. The remaining bits are lost, and the frame after that starts the next entry.
- R7: If the first byte is read in full and the second frame ends early, the rest of that entry is dropped. The next frame starts the next entry's first byte.
- R8: An entry leaves the buffer when its second frame starts, and not when its first byte is read. `count` therefore drops at the second chip-select fall for that entry.
- R9: A push arriving in the same cycle as a pop leaves `count` unchanged. No stored entry is overwritten in that case, even if the buffer is full.
- R10: A clear empties the buffer (`count` 0, `empty` 1) and resets any partial read position. A push in the same cycle as a clear is discarded.
- R11: If an overwrite discards an entry whose first byte was partly or fully read, the next frame starts at the first byte of the new oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Single-cycle strobe that stores `push_data` |
| push_data | input | 12 | Conversion result to store |
| clear | input | 1 | Single-cycle strobe that empties the buffer |
| cs_n | input | 1 | Active-low serial frame select |
| sclk | input | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data output |
| sdo_en | output | 1 | Output enable for `sdo` (0 means the pad is high impedance) |
| count | output | 5 | Number of stored results, 0 to 16 |
| empty | output | 1 | High when no result is stored |

## Verification
The bench goes after the partial-frame rules:
- A design that reset the read position at the end of a short first-byte frame would repeat the high byte instead of continuing the stream.
- A design that kept the position after a short second frame would leak the dropped bits into the next entry.

Overwrite is tested with a half-read head. Getting it wrong either replays the low byte of a discarded result or loses an extra entry. The pop cycle is hit with a push into a full buffer, where a wrong design would discard a live entry. A push arriving with a clear, and a clear after a partial read, are also tested; a wrong design keeps a stale entry or a stale bit offset.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
    parameter int unsigned RF_DATA_W = 12;
    parameter int unsigned RF_DEPTH  = 16;
    parameter int unsigned RF_BYTE_W = 8;
    parameter int unsigned RF_SYNC_N = 2;

    typedef enum logic [1:0] {
        SO_IDLE  = 2'd0,
        SO_LEAD  = 2'd1,
        SO_TRAIL = 2'd2,
        SO_VOID  = 2'd3
    } so_state_e;
endpackage

// File: rtl/rfifo_sync.sv
module rfifo_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff[0] <= RST_VAL;
                else        ff[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff[g] <= RST_VAL;
                else        ff[g] <= ff[g-1];
            end
        end
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/rfifo_store.sv
module rfifo_store #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              clear,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              overwrite
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, do_pop, advance_rd;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full       = (count == CNT_W'(DEPTH));
    assign empty      = (count == '0);
    assign do_pop     = pop && !empty && !clear;
    assign overwrite  = push && full && !do_pop && !clear;
    assign advance_rd = do_pop || overwrite;
    assign head       = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push && !clear) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)       wr_ptr <= ptr_next(wr_ptr);
            if (advance_rd) rd_ptr <= ptr_next(rd_ptr);
            if (push && !advance_rd)      count <= count + CNT_W'(1);
            else if (!push && do_pop)     count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/rfifo_serout.sv
module rfifo_serout
    import rfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_fall,
    input  logic [DATA_W-1:0] head,
    input  logic              empty,
    input  logic              drop,
    output logic              pop,
    output logic              sdo,
    output logic              sdo_en
);
    localparam int unsigned ENTRY_W = 2 * BYTE_W;
    localparam int unsigned PAD_W   = ENTRY_W - DATA_W;
    localparam int unsigned POS_W   = $clog2(BYTE_W + 1);

    so_state_e          state, state_nx;
    logic [ENTRY_W-1:0] shreg, word, shifted;
    logic [POS_W-1:0]   pos, fcnt;
    logic               lost;

    assign word    = {{PAD_W{1'b0}}, head};
    assign shifted = word << pos;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SO_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SO_IDLE: begin
                if (cs_fall) begin
                    if (empty)           state_nx = SO_VOID;
                    else if (pos == '0)  state_nx = SO_LEAD;
                    else                 state_nx = SO_TRAIL;
                end
            end
            SO_LEAD, SO_TRAIL, SO_VOID: begin
                if (cs_rise) state_nx = SO_IDLE;
            end
        endcase
    end

    // datapath: shift register, entry bit position, frame bit count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            pos   <= '0;
            fcnt  <= '0;
            lost  <= 1'b0;
        end else begin
            unique case (state)
                SO_IDLE: begin
                    if (cs_fall) begin
                        shreg <= empty ? '0 : shifted;
                        fcnt  <= '0;
                        lost  <= drop;
                    end else if (drop) begin
                        pos <= '0;
                    end
                end
                SO_LEAD: begin
                    if (cs_rise) begin
                        pos <= (lost || drop) ? '0 : fcnt;
                    end else begin
                        if (drop) lost <= 1'b1;
                        if (sclk_fall) begin
                            shreg <= shreg << 1;
                            if (fcnt != POS_W'(BYTE_W)) fcnt <= fcnt + POS_W'(1);
                        end
                    end
                end
                SO_TRAIL: begin
                    if (cs_rise)        pos   <= '0;
                    else if (sclk_fall) shreg <= shreg << 1;
                end
                SO_VOID: begin
                    shreg <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pop    = (state == SO_IDLE) && cs_fall && !empty && (pos != '0);
        sdo_en = (state != SO_IDLE);
        sdo    = sdo_en && shreg[ENTRY_W-1];
    end
endmodule

// File: rtl/conv_result_fifo.sv
module conv_result_fifo
    import rfifo_pkg::*;
#(
    parameter int unsigned DATA_W = RF_DATA_W,
    parameter int unsigned DEPTH  = RF_DEPTH,
    parameter int unsigned BYTE_W = RF_BYTE_W,
    parameter int unsigned SYNC_N = RF_SYNC_N,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              clear,
    input  logic              cs_n,
    input  logic              sclk,
    output logic              sdo,
    output logic              sdo_en,
    output logic [CNT_W-1:0]  count,
    output logic              empty
);
    logic              cs_s, cs_d, sclk_s, sclk_d;
    logic              cs_fall, cs_rise, sclk_fall;
    logic              pop, overwrite;
    logic [DATA_W-1:0] head;

    rfifo_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) cs_sync_i (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
    rfifo_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) sclk_sync_i (
        .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = cs_d && !cs_s;
    assign cs_rise   = !cs_d && cs_s;
    assign sclk_fall = sclk_d && !sclk_s && !cs_s;

    rfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) store_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .clear(clear), .head(head), .count(count),
        .empty(empty), .overwrite(overwrite));

    rfifo_serout #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) serout_i (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_fall(sclk_fall), .head(head), .empty(empty),
        .drop(overwrite || clear), .pop(pop), .sdo(sdo), .sdo_en(sdo_en));
endmodule

// File: rtl/conv_result_fifo_chk.sv
module conv_result_fifo_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic             clear,
    input logic             sdo,
    input logic             sdo_en,
    input logic [CNT_W-1:0] count,
    input logic             empty
);
    // R1
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R2
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && push && !clear) |=> (count == CNT_W'(DEPTH)));

    // R4
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> !sdo);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (count == $past(count) || count == $past(count) + CNT_W'(1)
                    || count + CNT_W'(1) == $past(count)));

    // R10
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (empty && count == '0));
endmodule

bind conv_result_fifo conv_result_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .push(push), .clear(clear),
    .sdo(sdo), .sdo_en(sdo_en), .count(count), .empty(empty));

// File: tb/conv_result_fifo_tb_top.sv
module conv_result_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0;
    logic [11:0] push_data = '0;
    logic        clear = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdo, sdo_en, empty;
    logic [4:0]  count;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    conv_result_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .clear(clear), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdo_en(sdo_en),
        .count(count), .empty(empty));

    function automatic logic [11:0] vpat(input int i);
        return 12'(i * 257 + 3);
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_push(input logic [11:0] d);
        @(negedge clk);
        push = 1'b1; push_data = d;
        @(negedge clk);
        push = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // one frame of nbits; optional push timed to the cycle the frame start is acted on
    task automatic spi_read(input int nbits, output logic [7:0] val,
                            input bit inject = 1'b0, input logic [11:0] inj = '0);
        val = '0;
        @(negedge clk);
        cs_n = 1'b0;
        if (inject) begin
            wait_clk(2);
            push = 1'b1; push_data = inj;
            wait_clk(1);
            push = 1'b0;
            wait_clk(3);
        end else begin
            wait_clk(6);
        end
        for (int i = 0; i < nbits; i++) begin
            val  = {val[6:0], sdo};
            sclk = 1'b1;
            wait_clk(6);
            sclk = 1'b0;
            wait_clk(6);
        end
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic t_reset();
        chk(count, 0, "R1 count after reset");
        chk(empty, 1, "R1 empty after reset");
        chk(sdo_en, 0, "R4 sdo_en idle");
        chk(sdo, 0, "R4 sdo idle");
    endtask

    task automatic t_basic();
        logic [7:0] b;
        do_push(12'hABC); do_push(12'h123); do_push(12'hF0F);
        chk(count, 3, "R1 count after three pushes");
        chk(empty, 0, "R1 empty with data");
        spi_read(8, b); chk(b, 8'h0A, "R3 high byte");
        chk(count, 3, "R8 no pop after first byte");
        spi_read(8, b); chk(b, 8'hBC, "R3 low byte");
        chk(count, 2, "R8 pop at second frame");
        spi_read(8, b); chk(b, 8'h01, "R3 second entry high");
        spi_read(8, b); chk(b, 8'h23, "R3 second entry low");
        spi_read(8, b); chk(b, 8'h0F, "R3 third entry high");
        spi_read(8, b); chk(b, 8'h0F, "R3 third entry low");
        chk(count, 0, "R1 drained");
    endtask

    task automatic t_hiz();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(6);
        chk(sdo_en, 1, "R4 sdo_en in frame");
        cs_n = 1'b1;
        wait_clk(6);
        chk(sdo_en, 0, "R4 sdo_en after frame");
        chk(sdo, 0, "R4 sdo after frame");
    endtask

    task automatic t_empty();
        logic [7:0] b;
        spi_read(8, b); chk(b, 8'h00, "R5 empty frame zeros");
        chk(count, 0, "R5 count unchanged");
    endtask

    task automatic t_partial_first();
        logic [7:0] b;
        do_push(12'h5A3); do_push(12'h777);
        spi_read(3, b); chk(b, 8'h00, "R6 three lead bits");
        chk(count, 2, "R6 entry kept after short lead");
        spi_read(8, b); chk(b, 8'h2D, "R6 continued stream bits 3..10");
        chk(count, 1, "R6 entry gone after continuation");
        spi_read(8, b); chk(b, 8'h07, "R6 next entry high");
        spi_read(8, b); chk(b, 8'h77, "R6 next entry low");
    endtask

    task automatic t_partial_second();
        logic [7:0] b;
        do_push(12'h9C4); do_push(12'h3E1);
        spi_read(8, b); chk(b, 8'h09, "R7 high byte");
        spi_read(5, b); chk(b, 8'h18, "R7 five low bits");
        spi_read(8, b); chk(b, 8'h03, "R7 next entry high");
        spi_read(8, b); chk(b, 8'hE1, "R7 next entry low");
        chk(count, 0, "R7 drained");
    endtask

    task automatic t_overwrite();
        logic [7:0] b;
        do_clear();
        for (int i = 0; i < 17; i++) do_push(vpat(i));
        chk(count, 16, "R2 count held at full");
        for (int i = 1; i < 17; i++) begin
            spi_read(8, b); chk(b, 32'(vpat(i) >> 8), "R2 order high");
            spi_read(8, b); chk(b, 32'(vpat(i) & 12'hFF), "R2 order low");
        end
        chk(count, 0, "R2 drained");
    endtask

    task automatic t_same_cycle();
        logic [7:0] b;
        for (int i = 0; i < 16; i++) do_push(vpat(i));
        spi_read(8, b); chk(b, 8'h00, "R9 head high");
        spi_read(8, b, 1'b1, 12'hFAB); chk(b, 8'h03, "R9 head low");
        chk(count, 16, "R9 count with push and pop");
        spi_read(8, b); chk(b, 8'h01, "R9 next entry intact");
        do_clear();
    endtask

    task automatic t_overwrite_partial();
        logic [7:0] b;
        for (int i = 0; i < 16; i++) do_push(vpat(i));
        spi_read(8, b); chk(b, 8'h00, "R11 head high");
        do_push(12'hAAA);
        chk(count, 16, "R11 count after overwrite");
        spi_read(8, b); chk(b, 8'h01, "R11 restart at new head");
        spi_read(8, b); chk(b, 8'h04, "R11 new head low");
        do_clear();
    endtask

    task automatic t_clear();
        logic [7:0] b;
        do_push(12'h111); do_push(12'h222);
        spi_read(4, b); chk(b, 8'h00, "R10 partial lead");
        do_clear();
        chk(count, 0, "R10 count after clear");
        chk(empty, 1, "R10 empty after clear");
        @(negedge clk);
        push = 1'b1; push_data = 12'h555; clear = 1'b1;
        @(negedge clk);
        push = 1'b0; clear = 1'b0;
        chk(count, 0, "R10 push lost to clear");
        do_push(12'h6B2);
        spi_read(8, b); chk(b, 8'h06, "R10 position reset");
        spi_read(8, b); chk(b, 8'hB2, "R10 low byte");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_basic();
        t_hiz();
        t_empty();
        t_partial_first();
        t_partial_second();
        t_overwrite();
        t_same_cycle();
        t_overwrite_partial();
        t_clear();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule